// File: doc/BRIEF.md
# Peripheral Software Reset Controller

This block holds a small bank of control registers through which software places individual peripheral units into reset. Every bit of the unit registers stands for one unit. The unit numbering matches the bit numbering of the clock-gating registers, so one index table serves both banks. A unit held in reset has its reset line asserted in every clock domain that the unit uses. A separate control register carries a request bit that resets the whole system, including the processor, for a fixed number of cycles. That bit then clears itself.

Software reaches the registers over a simple word-wide bus with single-cycle write strobes and registered reads. Each per-domain reset output comes from its own synchronizer. The synchronizer asserts as soon as its source rises, and releases only after two edges of the domain clock.

Top module: `srst_ctrl`

## Requirements
- R1: While `rst` is high, every bit of `unit_rst` is 1 and `sys_rst_req` is 0. After `rst` falls, `unit_rst` releases to 0, and every register reads 0.
- R2: A write with `wr_en` at address r, where r < NUM_REGS, stores `wdata` in unit register r. When `rd_en` is sampled at a clock edge, `rd_data` shows the addressed register in the cycle that follows.
- R3: Bit b of unit register r controls unit r*REG_W+b. In domain d that unit's reset is `unit_rst[d*NUM_REGS*REG_W + r*REG_W + b]`, and it is 1 exactly while the bit holds 1, after synchronization.
- R4: Setting a unit bit asserts the unit's reset outputs with no wait for any domain clock. Clearing the bit keeps the outputs high until two rising edges of each domain's clock have passed.
- R5: A single unit bit drives that unit's reset line in all N_DOM clock domains.
- R6: Writing 1 to bit 0 of the control register at address NUM_REGS raises `sys_rst_req` from the cycle after the write. It stays high for exactly SYS_HOLD cycles and then clears by itself. While it is high, bit 0 of the control register reads 1. Afterwards it reads 0.
- R7: From the cycle in which `sys_rst_req` rises, every `unit_rst` bit stays 1 for as long as the system reset lasts. All unit registers are cleared to 0 by the request.
- R8: Unit-register writes are discarded while `sys_rst_req` is high, including a write at the clock edge that ends it. A write one cycle later is stored.
- R9: Writing 0 to bit 0 of the control register has no effect. Bits 1 and above of the control register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bank clock |
| rst | input | 1 | Synchronous active-high reset of the bank |
| dom_clk | input | N_DOM | One clock per peripheral clock domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | $clog2(NUM_REGS+1) | Register address (NUM_REGS selects the control register) |
| wdata | input | REG_W | Write data |
| rd_data | output | REG_W | Registered read data |
| sys_rst_req | output | 1 | Whole-system reset request |
| unit_rst | output | N_DOM*NUM_REGS*REG_W | Per-unit, per-domain reset lines |

## Verification
Two functions can fall in the same cycle: a software write to a unit register, and the self-timed expiry of the system reset that clears and locks those registers. The bench issues the request and counts the high cycles of `sys_rst_req`. It then drives a unit write onto exactly the clock edge at which the request drops, and a second write one cycle later. It reads the register back after each write. The first write must leave 0, and the second must be stored.

// File: rtl/srst_pkg.sv
package srst_pkg;
  // bit of the control register that requests a whole-system reset
  localparam int SYS_REQ_BIT = 0;
  // minimum depth of a release synchronizer
  localparam int MIN_SYNC = 2;
endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
  parameter int STAGES = 2
) (
  input  logic dclk,
  input  logic src,
  output logic rst_o
);
  logic [STAGES-1:0] sh;

  // asynchronous assertion, release shifted in by the domain clock
  always_ff @(posedge dclk or posedge src) begin
    if (src) sh <= '1;
    else     sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_o = sh[STAGES-1];
endmodule

// File: rtl/srst_regs.sv
module srst_regs
  import srst_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 8,
  parameter int SYS_HOLD = 4,
  parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rd_data,
  output logic                          sys_req_o,
  output logic [NUM_REGS*REG_W-1:0]     src_o
);
  localparam int CNT_W = $clog2(SYS_HOLD + 1);
  localparam logic [ADDR_W-1:0] SYS_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [CNT_W-1:0]  HOLD_V   = CNT_W'(SYS_HOLD);

  logic [REG_W-1:0] bank   [NUM_REGS];
  logic [REG_W-1:0] bank_n [NUM_REGS];
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             busy, sys_hit, unit_wr;
  logic [NUM_REGS*REG_W-1:0] flat_n;

  assign busy    = (cnt != '0);
  assign sys_hit = wr_en && (addr == SYS_ADDR) && wdata[SYS_REQ_BIT] && !busy;
  assign unit_wr = wr_en && (addr < SYS_ADDR) && !busy;

  always_comb begin
    if (sys_hit)   cnt_n = HOLD_V;
    else if (busy) cnt_n = cnt - 1'b1;
    else           cnt_n = '0;
  end

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sys_hit)                                   bank_n[r] = '0;
      else if (unit_wr && (addr == ADDR_W'(r)))      bank_n[r] = wdata;
      else                                           bank_n[r] = bank[r];
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign flat_n[g*REG_W +: REG_W] = bank_n[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) bank[r] <= '0;
      cnt       <= '0;
      sys_req_o <= 1'b0;
      src_o     <= '1;
      rd_data   <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) bank[r] <= bank_n[r];
      cnt       <= cnt_n;
      sys_req_o <= (cnt_n != '0);
      src_o     <= (cnt_n != '0) ? '1 : flat_n;
      if (rd_en) begin
        if (addr < SYS_ADDR)       rd_data <= bank[addr];
        else if (addr == SYS_ADDR) rd_data <= {{(REG_W-1){1'b0}}, busy};
        else                       rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int NUM_REGS    = 3,
  parameter int REG_W       = 8,
  parameter int N_DOM       = 2,
  parameter int SYS_HOLD    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_REGS + 1),
  parameter int UNITS       = NUM_REGS * REG_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DOM-1:0]       dom_clk,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       rd_data,
  output logic                   sys_rst_req,
  output logic [N_DOM*UNITS-1:0] unit_rst
);
  localparam int STG = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

  logic [UNITS-1:0] src;

  srst_regs #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .SYS_HOLD(SYS_HOLD), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .sys_req_o(sys_rst_req), .src_o(src)
  );

  generate
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      for (genvar u = 0; u < UNITS; u++) begin : g_unit
        srst_sync #(.STAGES(STG)) u_sync (
          .dclk(dom_clk[d]), .src(src[u]), .rst_o(unit_rst[d*UNITS + u])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/srst_chk.sv
module srst_chk #(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 8,
  parameter int N_DOM    = 2,
  parameter int SYS_HOLD = 4,
  parameter int ADDR_W   = 2,
  parameter int UNITS    = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      addr,
  input logic [REG_W-1:0]       wdata,
  input logic [REG_W-1:0]       rd_data,
  input logic                   sys_rst_req,
  input logic [N_DOM*UNITS-1:0] unit_rst
);
  localparam logic [ADDR_W-1:0] SYS_ADDR = ADDR_W'(NUM_REGS);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)              hi_cnt <= '0;
    else if (sys_rst_req) hi_cnt <= hi_cnt + 1;
    else                  hi_cnt <= '0;
  end

  // R6
  sys_len_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> (hi_cnt < SYS_HOLD));

  // R6
  sys_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> $past(wr_en && (addr == SYS_ADDR) && wdata[0]));

  // R7
  sys_all_units_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> (&unit_rst));

  // R8
  busy_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_req && rd_en && (addr < SYS_ADDR)) |=> (rd_data == '0));

  // R9
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == SYS_ADDR)) |=> (rd_data[REG_W-1:1] == '0));
endmodule

bind srst_ctrl srst_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .N_DOM(N_DOM),
  .SYS_HOLD(SYS_HOLD), .ADDR_W(ADDR_W), .UNITS(UNITS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_data(rd_data), .sys_rst_req(sys_rst_req),
  .unit_rst(unit_rst)
);

// File: tb/sim_srst_ctrl.sv
`timescale 1ns/1ps
module sim_srst_ctrl;
  localparam int NR = 3, RW = 8, ND = 2, HOLD = 4, AW = 2, UN = NR * RW;

  typedef struct packed { logic wr; logic [1:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 8'h5A}, '{1'b1, 2'd1, 8'hC3}, '{1'b1, 2'd2, 8'h81},
    '{1'b0, 2'd0, 8'h5A}, '{1'b0, 2'd1, 8'hC3}, '{1'b0, 2'd2, 8'h81},
    '{1'b1, 2'd1, 8'h00}, '{1'b0, 2'd1, 8'h00}
  };

  logic clk = 0, rst = 1;
  logic [ND-1:0] dclk = '0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rd_data;
  logic sys_rst_req;
  logic [ND*UN-1:0] unit_rst;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;
  always #3 dclk[0] = ~dclk[0];
  always #5 dclk[1] = ~dclk[1];

  srst_ctrl u0 (
    .clk(clk), .rst(rst), .dom_clk(dclk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .sys_rst_req(sys_rst_req), .unit_rst(unit_rst)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at a negedge; the write lands on the next rising edge
  task automatic do_write(input logic [AW-1:0] a, input logic [RW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [RW-1:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  function automatic logic [RW-1:0] slice(input int dom, input int r);
    return unit_rst[dom*UN + r*RW +: RW];
  endfunction

  initial begin
    #(200000 * 4);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [RW-1:0] rv;
    // R1 reset state
    repeat (5) @(negedge clk);
    chk("R1 resets held during rst", 64'(unit_rst), 64'({ND*UN{1'b1}}));
    chk("R1 sys req low in rst", 64'(sys_rst_req), 64'd0);
    rst = 0;
    repeat (15) @(negedge clk);
    chk("R1 resets released", 64'(unit_rst), 64'd0);
    do_read(2'd0, rv); chk("R1 reg0 zero", 64'(rv), 64'd0);
    do_read(2'd3, rv); chk("R1 ctrl zero", 64'(rv), 64'd0);

    // R2 table walk
    foreach (VECS[i]) begin
      if (VECS[i].wr) do_write(VECS[i].a, VECS[i].d);
      else begin
        do_read(VECS[i].a, rv);
        chk("R2 readback", 64'(rv), 64'(VECS[i].d));
      end
    end

    // R3 R5 bit to unit mapping in every domain
    repeat (15) @(negedge clk);
    for (int d = 0; d < ND; d++) begin
      chk("R3 R5 reg0 lines", 64'(slice(d, 0)), 64'h5A);
      chk("R3 R5 reg1 lines", 64'(slice(d, 1)), 64'h00);
      chk("R3 R5 reg2 lines", 64'(slice(d, 2)), 64'h81);
    end

    // R4 immediate assert, delayed release
    do_write(2'd1, 8'h08);
    chk("R4 assert dom0", 64'(unit_rst[0*UN + 11]), 64'd1);
    chk("R4 assert dom1", 64'(unit_rst[1*UN + 11]), 64'd1);
    do_write(2'd1, 8'h00);
    chk("R4 held after clear dom0", 64'(unit_rst[0*UN + 11]), 64'd1);
    chk("R4 held after clear dom1", 64'(unit_rst[1*UN + 11]), 64'd1);
    repeat (10) @(negedge clk);
    chk("R4 released", 64'(slice(0, 1)) | 64'(slice(1, 1)), 64'd0);

    // R9 control writes without bit 0
    do_write(2'd3, 8'h00);
    chk("R9 zero write no req", 64'(sys_rst_req), 64'd0);
    do_write(2'd3, 8'hFE);
    chk("R9 upper bits no req", 64'(sys_rst_req), 64'd0);
    do_read(2'd3, rv); chk("R9 ctrl reads zero", 64'(rv), 64'd0);
    chk("R9 reg0 untouched", 64'(slice(0, 0)), 64'h5A);

    // R6 R7 R8 system reset and coincident write at its expiry
    do_write(2'd3, 8'h01);
    chk("R6 req high cycle 1", 64'(sys_rst_req), 64'd1);
    chk("R7 all lines asserted", 64'(unit_rst), 64'({ND*UN{1'b1}}));
    do_read(2'd3, rv); chk("R6 ctrl reads 1 while active", 64'(rv), 64'd1);
    chk("R6 req high cycle 2", 64'(sys_rst_req), 64'd1);
    do_read(2'd0, rv); chk("R7 reg0 cleared", 64'(rv), 64'd0);
    chk("R6 req high cycle 3", 64'(sys_rst_req), 64'd1);
    @(negedge clk);
    chk("R6 req high cycle 4", 64'(sys_rst_req), 64'd1);
    do_write(2'd0, 8'hAA);   // lands on the expiry edge
    chk("R6 req self-cleared", 64'(sys_rst_req), 64'd0);
    do_read(2'd0, rv); chk("R8 write at expiry ignored", 64'(rv), 64'd0);
    do_read(2'd3, rv); chk("R6 ctrl reads 0 after", 64'(rv), 64'd0);
    do_write(2'd0, 8'h55);
    do_read(2'd0, rv); chk("R8 write after expiry stored", 64'(rv), 64'h55);
    do_read(2'd2, rv); chk("R7 reg2 cleared", 64'(rv), 64'd0);
    repeat (15) @(negedge clk);
    chk("R3 lines follow after sys", 64'(slice(0, 0)) | (64'(slice(1, 2)) << 8), 64'h55);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule